// File: doc/BRIEF.md
# Cascadable Counter Bank with Coherent Snapshot

The bank holds four 16-bit counters on one clock. Each counter can be stopped, can count a shared primary tick up or down, or can run in cascade mode. In cascade mode it counts the terminal events of another counter that it selects. Every terminal event carries the direction of the step that produced it. A cascaded counter therefore increments when its source rolls over upward and decrements when its source borrows downward. Two, three or four counters chained this way behave as one wide counter of up to 64 bits, or as a mixed-radix counter when the limits are below full scale.

Reading the bank has two forms. A live read returns the current value of the indexed counter. In the same cycle it copies all four counters into their hold registers. A hold read returns the stored copy for the indexed counter and leaves every copy unchanged. Software can therefore take one live read of any stage and then fetch the other words of a chained value from the hold registers, so that every word comes from the same instant.

Top module: `casc_counter_bank`

## Requirements
- R1: After synchronous reset, every counter, every hold register, `rd_data_o` and `cmp_evt_o` are zero.
- R2: Mode code 3'b001 counts one step on each cycle with `tick_i` high, up when the counter's `dir_down_i` bit is 0 and down when it is 1. Mode 3'b000 and every code other than 3'b001 and 3'b111 leave the counter unchanged.
- R3: The terminal value is the compare value when stepping up and zero when stepping down. On a step taken from the terminal value, the counter's `cmp_evt_o` bit is high in the following cycle for one cycle. With the `reinit_i` bit set, that step loads zero when counting up and the compare value when counting down. With the bit clear, the step wraps modulo 2^16.
- R4: Mode code 3'b111 selects cascade. The counter takes one step in the cycle in which the selected source's terminal event is present on `cmp_evt_o`. The step is up if the source's event came from an upward step and down if it came from a downward step. The source index is the 2-bit field at bits [2i+1:2i] of `src_sel_i`.
- R5: A counter in cascade mode that selects its own index never changes value.
- R6: With each stage cascaded from the previous one, the stages together hold the exact mixed-radix count of the primary ticks, in both directions. With compare values of 16'hFFFF this gives a wide binary count with carry and borrow. Stage k reaches its final value k cycles after the last tick.
- R7: A live read (`rd_i` high, `rd_hold_i` low) returns the value counter `rd_idx_i` had in the read cycle on `rd_data_o` one cycle later. In the same cycle it copies all four counters into their hold registers.
- R8: A hold read (`rd_i` high, `rd_hold_i` high) returns hold register `rd_idx_i` on `rd_data_o` one cycle later and leaves all hold registers unchanged.
- R9: `rd_data_o` keeps its last value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every counter and register |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 12 | Per-counter 3-bit mode, counter i at bits [3i+2:3i] |
| src_sel_i | input | 8 | Per-counter 2-bit cascade source index |
| cmp_i | input | 64 | Per-counter 16-bit compare value, counter i at bits [16i+15:16i] |
| dir_down_i | input | 4 | Per-counter direction in tick mode, 1 = down |
| reinit_i | input | 4 | Per-counter reload-on-terminal enable |
| tick_i | input | 1 | Primary count tick shared by counters in tick mode |
| rd_i | input | 1 | Read strobe |
| rd_hold_i | input | 1 | 1 = read hold register, 0 = live read with capture |
| rd_idx_i | input | 2 | Counter index for the read |
| rd_data_o | output | 16 | Registered read data |
| cmp_evt_o | output | 4 | Per-counter terminal event, one cycle after the step |

## Verification
A counter value changes on the edge that samples the tick or source event. Its terminal event appears on `cmp_evt_o` one cycle after that edge. Each further cascade stage adds one cycle, and read data appears one cycle after the read edge. The bench drives inputs and checks outputs on falling edges. Event checks fall on the falling edge just after the stepping edge. Before any read of a chained value, the bench idles for at least as many cycles as the chain has stages. Read results go through a queue and are compared on the falling edge after the read edge.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
    localparam int NUM_CNT = 4;
    localparam int CNT_W   = 16;
    localparam int MODE_W  = 3;
    localparam int SEL_W   = $clog2(NUM_CNT);

    localparam logic [MODE_W-1:0] MODE_OFF  = 3'b000;
    localparam logic [MODE_W-1:0] MODE_TICK = 3'b001;
    localparam logic [MODE_W-1:0] MODE_CASC = 3'b111;

    // terminal event with the direction of the step that produced it
    typedef struct packed {
        logic up;
        logic dn;
    } cevt_t;

    function automatic logic [CNT_W-1:0] next_value(
        input logic [CNT_W-1:0] cur,
        input logic [CNT_W-1:0] cmp,
        input logic             down,
        input logic             reload
    );
        if (reload)
            return down ? cmp : '0;
        return down ? cur - 1'b1 : cur + 1'b1;
    endfunction
endpackage

// File: rtl/cc_unit.sv
`timescale 1ns/1ps
module cc_unit
    import cc_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [MODE_W-1:0]     mode_i,
    input  logic [SEL_W-1:0]      src_i,
    input  logic [CNT_W-1:0]      cmp_i,
    input  logic                  down_i,
    input  logic                  reinit_i,
    input  logic                  tick_i,
    input  cevt_t [NUM_CNT-1:0]   evt_all_i,
    output logic [CNT_W-1:0]      cnt_o,
    output cevt_t                 evt_o
);
    logic  self_sel, casc, tick_step, step, down, at_term;
    cevt_t src_evt;

    always_comb begin
        self_sel  = (src_i == SEL_W'(IDX));
        src_evt   = evt_all_i[src_i];
        casc      = (mode_i == MODE_CASC) && !self_sel;
        tick_step = (mode_i == MODE_TICK) && tick_i;
        step      = tick_step || (casc && (src_evt.up || src_evt.dn));
        down      = tick_step ? down_i : src_evt.dn;
        at_term   = down ? (cnt_o == '0) : (cnt_o == cmp_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_o <= '0;
            evt_o <= '0;
        end else begin
            evt_o.up <= step && at_term && !down;
            evt_o.dn <= step && at_term && down;
            if (step)
                cnt_o <= next_value(cnt_o, cmp_i, down, at_term && reinit_i);
        end
    end

    a_r2_idle_modes: assert property (@(posedge clk) disable iff (rst)
        (mode_i != MODE_TICK && mode_i != MODE_CASC) |=> $stable(cnt_o));

    a_r5_self_no_count: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_CASC && self_sel) |=> $stable(cnt_o));

    a_r4_casc_up: assert property (@(posedge clk) disable iff (rst)
        (casc && src_evt.up && !at_term) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

    a_r4_casc_dn: assert property (@(posedge clk) disable iff (rst)
        (casc && src_evt.dn && !at_term) |=> (cnt_o == CNT_W'($past(cnt_o) - 1'b1)));

    a_r3_up_reload: assert property (@(posedge clk) disable iff (rst)
        (step && !down && at_term && reinit_i) |=> (cnt_o == '0) && evt_o.up);

    a_r3_dn_reload: assert property (@(posedge clk) disable iff (rst)
        (step && down && at_term && reinit_i) |=> (cnt_o == $past(cmp_i)) && evt_o.dn);
endmodule

// File: rtl/cc_hold.sv
`timescale 1ns/1ps
module cc_hold
    import cc_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
    input  logic                          rd_i,
    input  logic                          rd_hold_i,
    input  logic [SEL_W-1:0]              rd_idx_i,
    output logic [CNT_W-1:0]              rd_data_o
);
    logic [NUM_CNT-1:0][CNT_W-1:0] hold_q;
    logic                          capture;

    assign capture = rd_i && !rd_hold_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            rd_data_o <= '0;
        end else if (rd_i) begin
            rd_data_o <= rd_hold_i ? hold_q[rd_idx_i] : cnt_i[rd_idx_i];
            if (capture)
                hold_q <= cnt_i;
        end
    end

    for (genvar k = 0; k < NUM_CNT; k++) begin : g_chk
        a_r7_capture_all: assert property (@(posedge clk) disable iff (rst)
            capture |=> (hold_q[k] == $past(cnt_i[k])));
    end

    a_r7_live_data: assert property (@(posedge clk) disable iff (rst)
        capture |=> (rd_data_o == $past(cnt_i[rd_idx_i])));

    a_r8_no_capture: assert property (@(posedge clk) disable iff (rst)
        (rd_i && rd_hold_i) |=> $stable(hold_q));

    a_r9_data_kept: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(rd_data_o));
endmodule

// File: rtl/casc_counter_bank.sv
`timescale 1ns/1ps
module casc_counter_bank
    import cc_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CNT*MODE_W-1:0] mode_i,
    input  logic [NUM_CNT*SEL_W-1:0]  src_sel_i,
    input  logic [NUM_CNT*CNT_W-1:0]  cmp_i,
    input  logic [NUM_CNT-1:0]        dir_down_i,
    input  logic [NUM_CNT-1:0]        reinit_i,
    input  logic                      tick_i,
    input  logic                      rd_i,
    input  logic                      rd_hold_i,
    input  logic [SEL_W-1:0]          rd_idx_i,
    output logic [CNT_W-1:0]          rd_data_o,
    output logic [NUM_CNT-1:0]        cmp_evt_o
);
    logic  [NUM_CNT-1:0][CNT_W-1:0] cnt_all;
    cevt_t [NUM_CNT-1:0]            evt_all;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        cc_unit #(.IDX(i)) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .mode_i    (mode_i[i*MODE_W +: MODE_W]),
            .src_i     (src_sel_i[i*SEL_W +: SEL_W]),
            .cmp_i     (cmp_i[i*CNT_W +: CNT_W]),
            .down_i    (dir_down_i[i]),
            .reinit_i  (reinit_i[i]),
            .tick_i    (tick_i),
            .evt_all_i (evt_all),
            .cnt_o     (cnt_all[i]),
            .evt_o     (evt_all[i])
        );
        assign cmp_evt_o[i] = evt_all[i].up | evt_all[i].dn;
    end

    cc_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .cnt_i     (cnt_all),
        .rd_i      (rd_i),
        .rd_hold_i (rd_hold_i),
        .rd_idx_i  (rd_idx_i),
        .rd_data_o (rd_data_o)
    );
endmodule

// File: tb/casc_counter_bank_test.sv
`timescale 1ns/1ps
module casc_counter_bank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mode_v = '0;
    logic [7:0]  src_v  = '0;
    logic [63:0] cmp_v  = '0;
    logic [3:0]  dn_v   = '0;
    logic [3:0]  rin_v  = '0;
    logic        tick = 1'b0;
    logic        rd = 1'b0;
    logic        rd_hold = 1'b0;
    logic [1:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic [3:0]  evt;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    logic rd_d = 1'b0;

    always #2.5 clk = ~clk;

    casc_counter_bank uut (
        .clk(clk), .rst(rst), .mode_i(mode_v), .src_sel_i(src_v), .cmp_i(cmp_v),
        .dir_down_i(dn_v), .reinit_i(rin_v), .tick_i(tick), .rd_i(rd),
        .rd_hold_i(rd_hold), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .cmp_evt_o(evt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // monitor: compares read data one cycle after each read edge
    always @(posedge clk) rd_d <= rd;
    always @(negedge clk) begin
        if (rd_d) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard empty", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, {16'h0, rd_data}, {16'h0, e.exp});
            end
        end
    end

    task automatic do_read(input logic [1:0] idx, input logic hold, input logic [15:0] exp,
                           input string tag);
        exp_t e;
        e.exp = exp;
        e.tag = tag;
        exp_q.push_back(e);
        rd = 1'b1;
        rd_hold = hold;
        rd_idx = idx;
        @(negedge clk);
        rd = 1'b0;
        rd_hold = 1'b0;
    endtask

    task automatic set_cfg(input int i, input logic [2:0] m, input logic [1:0] s,
                           input logic [15:0] c, input logic d, input logic r);
        mode_v[i*3 +: 3]  = m;
        src_v[i*2 +: 2]   = s;
        cmp_v[i*16 +: 16] = c;
        dn_v[i]  = d;
        rin_v[i] = r;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        mode_v = '0; src_v = '0; cmp_v = '0; dn_v = '0; rin_v = '0;
        tick = 1'b0;
        idle(2);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        reset_dut();

        // R1: reset state
        chk("R1 events after reset", {28'h0, evt}, 32'h0);
        for (int i = 0; i < 4; i++) do_read(2'(i), 1'b1, 16'h0000, "R1 hold after reset");
        for (int i = 0; i < 4; i++) do_read(2'(i), 1'b0, 16'h0000, "R1 live after reset");

        // R2: tick up, tick down with wrap, off and unused modes
        reset_dut();
        set_cfg(0, 3'b001, 2'd0, 16'd100, 1'b0, 1'b1);
        set_cfg(1, 3'b001, 2'd1, 16'd7,   1'b1, 1'b0);
        set_cfg(2, 3'b000, 2'd0, 16'd7,   1'b0, 1'b0);
        set_cfg(3, 3'b010, 2'd0, 16'd7,   1'b0, 1'b0);
        ticks(5);
        idle(1);
        do_read(2'd0, 1'b0, 16'd5,    "R2 tick up");
        do_read(2'd1, 1'b0, 16'hFFFB, "R2 tick down wrap");
        do_read(2'd2, 1'b0, 16'd0,    "R2 off mode ignores ticks");
        do_read(2'd3, 1'b0, 16'd0,    "R2 unused mode ignores ticks");

        // R3: terminal events and reload choices
        reset_dut();
        set_cfg(0, 3'b001, 2'd0, 16'd3, 1'b0, 1'b1);
        set_cfg(1, 3'b001, 2'd1, 16'd3, 1'b1, 1'b1);
        set_cfg(2, 3'b001, 2'd2, 16'd3, 1'b0, 1'b0);
        ticks(1);
        chk("R3 down terminal at zero", {28'h0, evt}, 32'h2);
        ticks(1);
        chk("R3 no event mid count", {28'h0, evt}, 32'h0);
        ticks(1);
        chk("R3 no event before terminal", {28'h0, evt}, 32'h0);
        ticks(1);
        chk("R3 up terminal events", {28'h0, evt}, 32'h5);
        idle(1);
        chk("R3 event lasts one cycle", {28'h0, evt}, 32'h0);
        do_read(2'd0, 1'b0, 16'd0, "R3 up reload to zero");
        do_read(2'd1, 1'b0, 16'd0, "R3 down reload to compare then count");
        do_read(2'd2, 1'b0, 16'd4, "R3 no reload steps past compare");

        // R4: cascade follows source direction
        reset_dut();
        set_cfg(0, 3'b001, 2'd0, 16'd1,    1'b0, 1'b1);
        set_cfg(1, 3'b111, 2'd0, 16'hFFFF, 1'b0, 1'b1);
        ticks(4);
        idle(2);
        do_read(2'd1, 1'b0, 16'd2, "R4 cascade increments");
        do_read(2'd0, 1'b0, 16'd0, "R4 source value");
        dn_v[0] = 1'b1;
        ticks(1);
        idle(2);
        do_read(2'd1, 1'b0, 16'd1, "R4 cascade decrements");
        ticks(2);
        idle(2);
        do_read(2'd1, 1'b0, 16'd0, "R4 cascade decrements again");
        do_read(2'd0, 1'b0, 16'd1, "R4 source reloaded down");

        // R5: self-selected cascade never counts
        reset_dut();
        set_cfg(0, 3'b001, 2'd0, 16'd0,    1'b0, 1'b1);
        set_cfg(1, 3'b111, 2'd1, 16'hFFFF, 1'b0, 1'b1);
        set_cfg(2, 3'b111, 2'd0, 16'hFFFF, 1'b0, 1'b1);
        ticks(5);
        idle(2);
        do_read(2'd1, 1'b0, 16'd0, "R5 self select ignored");
        do_read(2'd2, 1'b0, 16'd5, "R5 events were present");

        // R6, R7, R8, R9: four-stage radix-2 chain with snapshot reads
        reset_dut();
        set_cfg(0, 3'b001, 2'd0, 16'd1, 1'b0, 1'b1);
        set_cfg(1, 3'b111, 2'd0, 16'd1, 1'b0, 1'b1);
        set_cfg(2, 3'b111, 2'd1, 16'd1, 1'b0, 1'b1);
        set_cfg(3, 3'b111, 2'd2, 16'd1, 1'b0, 1'b1);
        ticks(11);
        idle(4);
        do_read(2'd0, 1'b0, 16'd1, "R6 chain bit0 / R7 live capture");
        ticks(1);
        idle(4);
        do_read(2'd1, 1'b1, 16'd1, "R7 hold bit1 from capture");
        do_read(2'd2, 1'b1, 16'd0, "R7 hold bit2 from capture");
        do_read(2'd3, 1'b1, 16'd1, "R6 R7 hold bit3 from capture");
        do_read(2'd0, 1'b1, 16'd1, "R8 hold unchanged by hold reads");
        do_read(2'd2, 1'b0, 16'd1, "R6 chain after twelve ticks");
        do_read(2'd0, 1'b1, 16'd0, "R7 new capture bit0");
        do_read(2'd1, 1'b1, 16'd0, "R7 new capture bit1");
        do_read(2'd3, 1'b1, 16'd1, "R8 new capture bit3");
        idle(3);
        chk("R9 read data kept", {16'h0, rd_data}, 32'h1);

        // R6: full-scale two-word carry and borrow
        reset_dut();
        set_cfg(0, 3'b001, 2'd0, 16'hFFFF, 1'b0, 1'b1);
        set_cfg(1, 3'b111, 2'd0, 16'hFFFF, 1'b0, 1'b1);
        ticks(65536);
        idle(2);
        do_read(2'd0, 1'b0, 16'h0000, "R6 low word after carry");
        do_read(2'd1, 1'b1, 16'h0001, "R6 high word carry");
        dn_v[0] = 1'b1;
        ticks(1);
        chk("R6 borrow event", {28'h0, evt}, 32'h1);
        idle(2);
        do_read(2'd1, 1'b0, 16'h0000, "R6 high word borrow");
        do_read(2'd0, 1'b1, 16'hFFFF, "R6 low word after borrow");

        idle(2);
        chk("scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule